// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator-based processor. Each operation combines the accumulator with a second operand. The operations are add, add with carry, subtract, subtract with borrow, AND, XOR, OR and compare, plus increment and decrement of either the accumulator or another register.

The result is available combinationally in the same cycle, together with a strobe that tells the surrounding datapath whether the accumulator should capture it. A five-bit status word is held in a register inside the block. That register updates on the clock edge when the enable is high, and its carry bit feeds the carry-using operations.

The status word holds sign, zero, nibble carry, even parity and carry. On subtraction the carry bit holds a borrow.

Top module: `acc_alu`

## Requirements
- R1: Opcode 0 (add) returns acc+opnd; opcode 1 (add with carry) returns acc+opnd+carry flag. Carry (flags[0]) takes the carry out of the top bit. Both assert acc_wr.
- R2: Opcode 2 (subtract) returns acc-opnd; opcode 3 (subtract with borrow) returns acc-opnd-carry flag. Carry is set when a borrow is needed. Opcode 7 (compare) computes as opcode 2 and updates all flags, but leaves acc_wr low.
- R3: Opcodes 4 (AND), 5 (XOR) and 6 (OR) return the bitwise result and assert acc_wr. They clear carry. Nibble carry (flags[2]) is set by AND and cleared by XOR and OR.
- R4: After any valid enabled operation, sign (flags[4]) equals the top bit of the result.
- R5: After any valid enabled operation, zero (flags[3]) is set exactly when the result is all zeros, including increment or decrement of a non-accumulator register.
- R6: After any valid enabled operation, parity (flags[1]) is set when the result holds an even number of one bits.
- R7: For addition, nibble carry is the carry from bit 3 into bit 4. For subtraction, compare and decrement, it is the borrow into bit 3's nibble.
- R8: Opcode 8 (increment) and opcode 9 (decrement) act on acc_in when tgt_acc is 1 and assert acc_wr. When tgt_acc is 0 they act on opnd_in and leave acc_wr low. Either way the carry flag is left unchanged.
- R9: When alu_en is low the flag register keeps its value.
- R10: Synchronous reset clears all five flags.
- R11: Opcodes 10 to 15 are no-operations: result equals acc_in, acc_wr is low, and the flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_en | input | 1 | Commit flag update this cycle |
| op | input | 4 | Operation select |
| tgt_acc | input | 1 | Increment/decrement target is the accumulator |
| acc_in | input | DATA_W | Accumulator value |
| opnd_in | input | DATA_W | Second operand or non-accumulator register |
| result | output | DATA_W | Operation result (combinational) |
| acc_wr | output | 1 | Accumulator should capture result |
| flags | output | 5 | {sign, zero, nibble carry, parity, carry} |

## Verification
The bench builds the block with its default widths: eight data bits and a four-bit nibble. With those widths every wrap point is reachable with byte-sized vectors. That covers the carry out at 0xFF+0x01, the borrow below zero, and the nibble boundary at 0x0F/0x10. Each vector first forces the carry flag to a chosen value, so that carry-in use and carry hold are both observed.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_AND = 4'd4,
        OP_XOR = 4'd5,
        OP_OR  = 4'd6,
        OP_CMP = 4'd7,
        OP_INC = 4'd8,
        OP_DEC = 4'd9
    } alu_op_e;

    typedef struct packed {
        logic sign;
        logic zero;
        logic aux;
        logic par;
        logic cy;
    } flags_t;

    localparam int FLAG_W = $bits(flags_t);

    function automatic logic op_valid(input logic [3:0] code);
        return code <= 4'd9;
    endfunction

    function automatic logic op_is_logic(input alu_op_e code);
        return (code == OP_AND) || (code == OP_XOR) || (code == OP_OR);
    endfunction

    function automatic logic op_writes_acc(input alu_op_e code, input logic to_acc);
        case (code)
            OP_CMP:         return 1'b0;
            OP_INC, OP_DEC: return to_acc;
            default:        return op_valid(code);
        endcase
    endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic              cin,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              aux
);
    localparam int HI_W = DATA_W - NIB_W;

    logic [DATA_W-1:0] y_eff;
    logic              c0;
    logic [NIB_W:0]    lo;
    logic [HI_W:0]     hi;

    always_comb begin
        y_eff = sub ? ~y : y;
        c0    = sub ? ~cin : cin;
        lo    = {1'b0, x[NIB_W-1:0]} + {1'b0, y_eff[NIB_W-1:0]} + {{NIB_W{1'b0}}, c0};
        hi    = {1'b0, x[DATA_W-1:NIB_W]} + {1'b0, y_eff[DATA_W-1:NIB_W]}
              + {{HI_W{1'b0}}, lo[NIB_W]};
        sum   = {hi[HI_W-1:0], lo[NIB_W-1:0]};
        cout  = hi[HI_W] ^ sub;
        aux   = lo[NIB_W] ^ sub;
    end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           code,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        always_comb begin
            case (code)
                OP_AND:  res[i] = a[i] & b[i];
                OP_XOR:  res[i] = a[i] ^ b[i];
                default: res[i] = a[i] | b[i];
            endcase
        end
    end
endmodule

// File: rtl/acc_alu_flagreg.sv
module acc_alu_flagreg
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic [DATA_W-1:0] res,
    input  logic              aux_n,
    input  logic              cy_n,
    output flags_t            q
);
    flags_t d;

    always_comb begin
        d.sign = res[DATA_W-1];
        d.zero = (res == '0);
        d.aux  = aux_n;
        d.par  = ~^res;
        d.cy   = cy_n;
    end

    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (upd) q <= d;
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                alu_en,
    input  logic [3:0]          op,
    input  logic                tgt_acc,
    input  logic [DATA_W-1:0]   acc_in,
    input  logic [DATA_W-1:0]   opnd_in,
    output logic [DATA_W-1:0]   result,
    output logic                acc_wr,
    output logic [FLAG_W-1:0]   flags
);
    alu_op_e           code;
    flags_t            fq;
    logic [DATA_W-1:0] src, as_x, as_y, as_sum, lg_res;
    logic              as_cin, as_sub, as_cout, as_aux;
    logic              aux_n, cy_n, upd;

    assign code = alu_op_e'(op);
    assign src  = tgt_acc ? acc_in : opnd_in;

    always_comb begin
        as_x   = acc_in;
        as_y   = opnd_in;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (code)
            OP_ADC:         as_cin = fq.cy;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBB: begin
                as_sub = 1'b1;
                as_cin = fq.cy;
            end
            OP_INC: begin
                as_x   = src;
                as_y   = '0;
                as_cin = 1'b1;
            end
            OP_DEC: begin
                as_x   = src;
                as_y   = '0;
                as_cin = 1'b1;
                as_sub = 1'b1;
            end
            default: ;
        endcase
    end

    acc_alu_addsub #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_addsub (
        .x(as_x), .y(as_y), .cin(as_cin), .sub(as_sub),
        .sum(as_sum), .cout(as_cout), .aux(as_aux)
    );

    acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .code(code), .a(acc_in), .b(opnd_in), .res(lg_res)
    );

    always_comb begin
        if (!op_valid(op)) begin
            result = acc_in;
            aux_n  = fq.aux;
            cy_n   = fq.cy;
        end else if (op_is_logic(code)) begin
            result = lg_res;
            aux_n  = (code == OP_AND);
            cy_n   = 1'b0;
        end else begin
            result = as_sum;
            aux_n  = as_aux;
            cy_n   = (code == OP_INC || code == OP_DEC) ? fq.cy : as_cout;
        end
        acc_wr = op_writes_acc(code, tgt_acc);
        upd    = alu_en && op_valid(op);
    end

    acc_alu_flagreg #(.DATA_W(DATA_W)) u_flags (
        .clk(clk), .rst(rst), .upd(upd), .res(result),
        .aux_n(aux_n), .cy_n(cy_n), .q(fq)
    );

    assign flags = fq;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              alu_en,
    input logic [3:0]        op,
    input logic              tgt_acc,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] opnd_in,
    input logic [DATA_W-1:0] result,
    input logic              acc_wr,
    input logic [4:0]        flags
);
    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> flags == 5'b0);

    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (rst)
        !alu_en |=> $stable(flags));

    assert_incdec_keeps_carry_R8: assert property (@(posedge clk) disable iff (rst)
        alu_en && (op == 4'd8 || op == 4'd9) |=> flags[0] == $past(flags[0]));

    assert_inc_register_R8: assert property (@(posedge clk) disable iff (rst)
        op == 4'd8 && !tgt_acc |-> result == DATA_W'(opnd_in + 1'b1) && !acc_wr);

    assert_logic_flags_R3: assert property (@(posedge clk) disable iff (rst)
        alu_en && op >= 4'd4 && op <= 4'd6
        |=> flags[0] == 1'b0 && flags[2] == ($past(op) == 4'd4));

    assert_sign_R4: assert property (@(posedge clk) disable iff (rst)
        alu_en && op <= 4'd9 |=> flags[4] == $past(result[DATA_W-1]));

    assert_zero_R5: assert property (@(posedge clk) disable iff (rst)
        alu_en && op <= 4'd9 |=> flags[3] == ($past(result) == '0));

    assert_parity_R6: assert property (@(posedge clk) disable iff (rst)
        alu_en && op <= 4'd9 |=> flags[1] == ~^$past(result));

    assert_compare_no_write_R2: assert property (@(posedge clk) disable iff (rst)
        op == 4'd7 |-> !acc_wr);

    assert_reserved_passive_R11: assert property (@(posedge clk) disable iff (rst)
        op > 4'd9 |-> result == acc_in && !acc_wr);

    assert_reserved_flags_R11: assert property (@(posedge clk) disable iff (rst)
        op > 4'd9 |=> $stable(flags));
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_chk (.*);

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       alu_en = 1'b0;
    logic [3:0] op = 4'd0;
    logic       tgt_acc = 1'b0;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] opnd_in = 8'h00;
    logic [7:0] result;
    logic       acc_wr;
    logic [4:0] flags;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    acc_alu u0 (
        .clk(clk), .rst(rst), .alu_en(alu_en), .op(op), .tgt_acc(tgt_acc),
        .acc_in(acc_in), .opnd_in(opnd_in), .result(result),
        .acc_wr(acc_wr), .flags(flags)
    );

    // {op, tgt_acc, carry_in, acc, opnd, exp_result, exp_wr, exp_flags{S,Z,AC,P,CY}}
    localparam int NV = 19;
    localparam logic [35:0] VEC [NV] = '{
        {4'd0, 1'b0, 1'b0, 8'h3A, 8'hC6, 8'h00, 1'b1, 5'b01111},
        {4'd0, 1'b0, 1'b1, 8'h12, 8'h34, 8'h46, 1'b1, 5'b00000},
        {4'd1, 1'b0, 1'b1, 8'h12, 8'h34, 8'h47, 1'b1, 5'b00010},
        {4'd1, 1'b0, 1'b1, 8'h7F, 8'h00, 8'h80, 1'b1, 5'b10100},
        {4'd2, 1'b0, 1'b0, 8'h10, 8'h01, 8'h0F, 1'b1, 5'b00110},
        {4'd2, 1'b0, 1'b0, 8'h05, 8'h07, 8'hFE, 1'b1, 5'b10101},
        {4'd3, 1'b0, 1'b1, 8'h05, 8'h05, 8'hFF, 1'b1, 5'b10111},
        {4'd3, 1'b0, 1'b0, 8'h44, 8'h22, 8'h22, 1'b1, 5'b00010},
        {4'd7, 1'b0, 1'b0, 8'h20, 8'h20, 8'h00, 1'b0, 5'b01010},
        {4'd7, 1'b0, 1'b0, 8'h10, 8'h20, 8'hF0, 1'b0, 5'b10011},
        {4'd4, 1'b0, 1'b1, 8'hF0, 8'h3C, 8'h30, 1'b1, 5'b00110},
        {4'd5, 1'b0, 1'b1, 8'hAA, 8'hFF, 8'h55, 1'b1, 5'b00010},
        {4'd6, 1'b0, 1'b1, 8'h80, 8'h01, 8'h81, 1'b1, 5'b10010},
        {4'd4, 1'b0, 1'b0, 8'h0F, 8'hF0, 8'h00, 1'b1, 5'b01110},
        {4'd8, 1'b1, 1'b1, 8'h0F, 8'h55, 8'h10, 1'b1, 5'b00101},
        {4'd8, 1'b0, 1'b0, 8'h33, 8'hFF, 8'h00, 1'b0, 5'b01110},
        {4'd9, 1'b0, 1'b1, 8'h00, 8'h01, 8'h00, 1'b0, 5'b01011},
        {4'd9, 1'b1, 1'b0, 8'h00, 8'h99, 8'hFF, 1'b1, 5'b10110},
        {4'd12, 1'b0, 1'b1, 8'h5A, 8'h3C, 8'h5A, 1'b0, 5'b01111}
    };

    function automatic string req_of(input logic [3:0] code);
        case (code)
            4'd0, 4'd1:       return "R1";
            4'd2, 4'd3, 4'd7: return "R2";
            4'd4, 4'd5, 4'd6: return "R3";
            4'd8, 4'd9:       return "R8";
            default:          return "R11";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive one enabled operation at a falling edge, let it commit
    task automatic run_op(input logic [3:0] code, input logic ta,
                          input logic [7:0] a, input logic [7:0] b, input logic en);
        @(negedge clk);
        op = code; tgt_acc = ta; acc_in = a; opnd_in = b; alu_en = en;
    endtask

    task automatic set_carry(input logic c);
        if (c) run_op(4'd0, 1'b0, 8'hFF, 8'h01, 1'b1);
        else   run_op(4'd4, 1'b0, 8'h00, 8'h00, 1'b1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10", "flags after reset", {3'b0, flags}, 8'h00);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            set_carry(VEC[i][30]);
            run_op(VEC[i][35:32], VEC[i][31], VEC[i][29:22], VEC[i][21:14], 1'b1);
            #1;
            check(req_of(VEC[i][35:32]), "result", result, VEC[i][13:6]);
            check(req_of(VEC[i][35:32]), "acc_wr", {7'b0, acc_wr}, {7'b0, VEC[i][5]});
            @(negedge clk);
            check("R4 R5 R6 R7", "flags", {3'b0, flags}, {3'b0, VEC[i][4:0]});
        end

        // R9: enable low leaves flags untouched
        set_carry(1'b1);
        run_op(4'd4, 1'b0, 8'h01, 8'h02, 1'b0);
        @(negedge clk);
        check("R9", "flags with enable low", {3'b0, flags}, 8'h0F);

        // R8: carry of 0 also held across increment
        set_carry(1'b0);
        run_op(4'd8, 1'b1, 8'h7F, 8'h00, 1'b1);
        #1;
        check("R8", "inc result", result, 8'h80);
        @(negedge clk);
        check("R8", "inc flags", {3'b0, flags}, 8'h14);

        // R10: reset in mid-run clears a non-zero status word
        set_carry(1'b1);
        @(negedge clk);
        rst = 1'b1; alu_en = 1'b0;
        @(negedge clk);
        check("R10", "flags after mid-run reset", {3'b0, flags}, 8'h00);
        rst = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule